// File: doc/BRIEF.md
# Reloadable Periodic Down-Counter Timer

The block is a 24-bit timer that counts down once per clock. It produces a periodic event that a processor can use as a system heartbeat. Software reaches it through a small word-wide register port. That port holds a control/status word, the value loaded after each expiry, the live count, and a constant calibration word that cannot be written.

The event occurs only when the count steps from one to zero. On the following clock the counter takes the programmed start value again, so a start value of R gives one event every R+1 clocks. A start value of zero is legal but never produces an event. At each event the block sets a sticky flag, and it can also pulse an interrupt line for one clock. Reading the control/status word clears the flag. Writing anything to the live count forces the count and the flag to zero.

The contents of the start value and the live count are not meant to be relied on after reset. Software programs both before it sets the enable bit.

Top module: `tick_timer`

## Requirements
- R1: The start value is 24 bits wide. Writes to bits 31:24 of that register have no effect, and those bits read as zero.
- R2: Registers are decoded on byte offsets: 0x10 control/status, 0x14 start value, 0x18 live count, 0x1C calibration. The calibration word always reads as the CALIB_VALUE parameter and ignores writes. Unused offsets read zero. Read data appears on the clock after `rd_en`, and `rd_data` is zero after a clock with no read.
- R3: A write of any value to the live count sets the count and the flag to zero on that clock, and it raises no interrupt.
- R4: While enabled, a non-zero count decreases by one each clock. A count of zero takes the start value on the next clock.
- R5: With a start value of zero, an enabled counter at zero stays at zero and never raises the flag or the interrupt.
- R6: An event happens only when an enabled count steps from 1 to 0. A start value of R gives exactly R+1 clocks between consecutive events.
- R7: The flag (control/status bit 16) is set by an event and stays set until a read of control/status. If an event and such a read fall on the same clock, the flag stays set.
- R8: `irq` is high for exactly one clock per event, and only when the interrupt-enable bit (control/status bit 1) is set.
- R9: When the enable bit (control/status bit 0) is clear, the count holds its value.
- R10: After reset, control/status reads zero, `irq` is low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter steps once per edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Byte offset inside the register window |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Registered read data |
| irq | output | 1 | One-clock interrupt pulse per event |

## Verification
On every clock, the assertions check four things:
- `irq` never lasts two clocks and is always accompanied by the flag.
- A zero count takes the start value, and a disabled count holds.
- A write to the live count clears both count and flag.
- Read data of the start value and calibration words keep their fixed bits.

Other properties only the bench scenarios can show:
- the exact spacing of R+1 clocks between events;
- the absence of any event with a zero start value;
- the flag's read-to-clear behaviour;
- the masking of the interrupt while the flag still rises.

A cycle-stepped bench model also compares every read and every `irq` sample during a long random mix of writes and reads.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // word index (byte offset >> 2) of each register in the window
  localparam int unsigned WIDX_CTRL   = 4;
  localparam int unsigned WIDX_RELOAD = 5;
  localparam int unsigned WIDX_CUR    = 6;
  localparam int unsigned WIDX_CALIB  = 7;

  // control/status bit positions
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_IE   = 1;
  localparam int unsigned BIT_FLAG = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_RELOAD,
    SEL_CUR,
    SEL_CALIB
  } reg_sel_e;
endpackage

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CNT_W       = 24,
  parameter logic [31:0] CALIB_VALUE = 32'h0000_2710
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  cur,
  input  logic              flag,
  output logic              en,
  output logic              ie,
  output logic [CNT_W-1:0]  reload,
  output logic              cur_wr,
  output logic              flag_rd,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  reg_sel_e sel;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    case (int'(a[ADDR_W-1:2]))
      WIDX_CTRL:   return SEL_CTRL;
      WIDX_RELOAD: return SEL_RELOAD;
      WIDX_CUR:    return SEL_CUR;
      WIDX_CALIB:  return SEL_CALIB;
      default:     return SEL_NONE;
    endcase
  endfunction

  assign sel     = decode(addr);
  assign cur_wr  = wr_en && (sel == SEL_CUR);
  assign flag_rd = rd_en && (sel == SEL_CTRL);

  logic unused_bits;
  assign unused_bits = ^{addr[1:0], wr_data[DATA_W-1:CNT_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= 1'b0;
      ie     <= 1'b0;
      reload <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_CTRL: begin
          en <= wr_data[BIT_EN];
          ie <= wr_data[BIT_IE];
        end
        SEL_RELOAD: reload <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL: begin
        rd_mux[BIT_EN]   = en;
        rd_mux[BIT_IE]   = ie;
        rd_mux[BIT_FLAG] = flag;
      end
      SEL_RELOAD: rd_mux = {{PAD_W{1'b0}}, reload};
      SEL_CUR:    rd_mux = {{PAD_W{1'b0}}, cur};
      SEL_CALIB:  rd_mux = CALIB_VALUE[DATA_W-1:0];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
    else            rd_data <= '0;
  end

  assert_reload_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_RELOAD) |=> (rd_data[DATA_W-1:CNT_W] == '0));

  assert_calib_fixed_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_CALIB) |=> (rd_data == CALIB_VALUE[DATA_W-1:0]));

  assert_idle_read_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ie,
  input  logic [CNT_W-1:0] reload,
  input  logic             cur_wr,
  input  logic             flag_rd,
  output logic [CNT_W-1:0] cur,
  output logic             flag,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic expire;
  assign expire = en && (cur == ONE) && !cur_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= '0;
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= expire && ie;
      if (cur_wr) begin
        cur  <= '0;
        flag <= 1'b0;
      end else begin
        if (en) begin
          if (cur == '0) cur <= reload;
          else           cur <= cur - ONE;
        end
        if (expire)       flag <= 1'b1;
        else if (flag_rd) flag <= 1'b0;
      end
    end
  end

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_irq_with_flag_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);

  assert_zero_loads_R4: assert property (@(posedge clk) disable iff (rst)
    (en && cur == '0 && !cur_wr) |=> (cur == $past(reload)));

  assert_cur_write_clears_R3: assert property (@(posedge clk) disable iff (rst)
    cur_wr |=> (cur == '0 && !flag && !irq));

  assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (rst)
    (!en && !cur_wr) |=> $stable(cur));

  assert_zero_reload_stays_R5: assert property (@(posedge clk) disable iff (rst)
    (en && reload == '0 && cur == '0 && !cur_wr) |=> (cur == '0 && !irq));
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CNT_W       = 24,
  parameter logic [31:0] CALIB_VALUE = 32'h0000_2710
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic             en, ie, cur_wr, flag_rd, flag;
  logic [CNT_W-1:0] reload, cur;

  tick_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CALIB_VALUE(CALIB_VALUE)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .cur(cur), .flag(flag), .en(en), .ie(ie),
    .reload(reload), .cur_wr(cur_wr), .flag_rd(flag_rd), .rd_data(rd_data)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .ie(ie), .reload(reload),
    .cur_wr(cur_wr), .flag_rd(flag_rd), .cur(cur), .flag(flag), .irq(irq)
  );
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam logic [31:0] CAL = 32'h0000_2710;
  localparam logic [7:0] A_CTRL = 8'h10, A_REL = 8'h14, A_CUR = 8'h18, A_CAL = 8'h1C;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  always #2 clk = ~clk;  // 250 MHz

  tick_timer i_tick_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  int checks = 0, fails = 0, pulses = 0, cyc = 0;

  // bench model, stepped from the requirements
  logic        m_en = 0, m_ie = 0, m_flag = 0, m_irq = 0;
  logic [23:0] m_rel = 0, m_cur = 0;
  logic [31:0] m_rd = 0;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      A_CTRL:  return {15'd0, m_flag, 14'd0, m_ie, m_en};
      A_REL:   return {8'd0, m_rel};
      A_CUR:   return {8'd0, m_cur};
      A_CAL:   return CAL;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en <= 0; m_ie <= 0; m_flag <= 0; m_irq <= 0; m_rel <= 0; m_cur <= 0; m_rd <= 0;
    end else begin
      m_rd  <= rd_en ? model_read(addr) : 32'd0;
      m_irq <= 1'b0;
      if (wr_en && addr == A_CTRL) begin m_en <= wr_data[0]; m_ie <= wr_data[1]; end
      if (wr_en && addr == A_REL) m_rel <= wr_data[23:0];
      if (wr_en && addr == A_CUR) begin
        m_cur <= 0; m_flag <= 0;
      end else begin
        if (m_en) m_cur <= (m_cur == 0) ? m_rel : m_cur - 24'd1;
        if (m_en && m_cur == 24'd1) begin m_flag <= 1'b1; m_irq <= m_ie; end
        else if (rd_en && addr == A_CTRL) m_flag <= 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // every clock: irq against the model (R8)
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (irq) pulses++;
      check(irq === m_irq, "R8", {31'd0, irq}, {31'd0, m_irq});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string req, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
    check(d === m_rd, req, d, m_rd);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, a1, a2;
    int p0, t1, t2;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    check(irq === 1'b0, "R10", {31'd0, irq}, 0);
    check(rd_data === 32'd0, "R10", rd_data, 0);
    rd(A_CTRL, "R10", d); check(d === 32'd0, "R10", d, 0);

    // R1: upper bits of start value dropped
    wr(A_REL, 32'hFFAB_CDEF);
    rd(A_REL, "R1", d); check(d === 32'h00AB_CDEF, "R1", d, 32'h00AB_CDEF);

    // R2: calibration read-only, unused offset reads zero
    wr(A_CAL, 32'hFFFF_FFFF);
    rd(A_CAL, "R2", d); check(d === CAL, "R2", d, CAL);
    rd(8'h00, "R2", d); check(d === 32'd0, "R2", d, 0);

    // R4: cur 0 -> 5 -> 4 across two enabled edges
    wr(A_REL, 32'd5); wr(A_CUR, 32'd77);
    wr(A_CTRL, 32'd1); wr(A_CTRL, 32'd0);
    rd(A_CUR, "R4", d); check(d === 32'd4, "R4", d, 4);

    // R9: disabled counter holds
    wr(A_REL, 32'd1000); wr(A_CUR, 0); wr(A_CTRL, 32'd1); idle(20); wr(A_CTRL, 32'd0);
    rd(A_CUR, "R9", a1); idle(10); rd(A_CUR, "R9", a2);
    check(a1 === a2 && a1 != 0 && a1 < 1000, "R9", a2, a1);

    // R6: period reload+1
    wr(A_REL, 32'd9); wr(A_CUR, 0); wr(A_CTRL, 32'd3);
    t1 = 0; t2 = 0;
    for (int k = 0; k < 200 && t2 == 0; k++) begin
      @(negedge clk);
      if (irq) begin if (t1 == 0) t1 = cyc; else t2 = cyc; end
    end
    check(t2 - t1 == 10, "R6", t2 - t1, 10);

    // R8: interrupt masked while flag still rises; R7: read clears flag
    wr(A_CTRL, 32'd0); rd(A_CTRL, "R7", d);
    wr(A_CUR, 0); wr(A_CTRL, 32'd1);
    p0 = pulses; idle(30); wr(A_CTRL, 32'd0);
    check(pulses == p0, "R8", pulses - p0, 0);
    rd(A_CTRL, "R7", d); check(d[16] === 1'b1, "R7", d, 32'h0001_0000);
    rd(A_CTRL, "R7", d); check(d[16] === 1'b0, "R7", d, 0);

    // R3: write to live count clears count and flag
    wr(A_CTRL, 32'd1); idle(25); wr(A_CTRL, 32'd0);
    wr(A_CUR, 32'h00FF_FFFF);
    rd(A_CUR, "R3", d); check(d === 32'd0, "R3", d, 0);
    rd(A_CTRL, "R3", d); check(d[16] === 1'b0, "R3", d, 0);

    // R5: start value zero never fires
    wr(A_REL, 0); wr(A_CUR, 0); wr(A_CTRL, 32'd3);
    p0 = pulses; idle(40);
    check(pulses == p0, "R5", pulses - p0, 0);
    rd(A_CUR, "R5", d); check(d === 32'd0, "R5", d, 0);
    rd(A_CTRL, "R5", d); check(d[16] === 1'b0, "R5", d, 0);

    // random mix against the model (R4, R6, R7)
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: wr(A_CTRL, {30'd0, 2'($urandom_range(0, 3))});
        1: wr(A_REL, ($urandom_range(0, 7) == 0) ? $urandom : 32'($urandom_range(0, 12)));
        2: wr(A_CUR, $urandom);
        3, 4: rd(A_CTRL, "R7", d);
        5, 6: rd(A_CUR, "R4", d);
        7: rd(8'($urandom_range(0, 8) << 2), "R2", d);
        default: idle($urandom_range(1, 15));
      endcase
    end
    finish_run();
  end
endmodule